// File: doc/BRIEF.md
# Timestamped Throttle Transition Recorder

This block keeps a history of a bank of throttle lines by writing an entry only when the sampled vector changes. Each entry joins the new vector state with the value of a free-running timestamp counter. The entries go into a deep first-in first-out store. Because idle periods cost no storage, the memory used depends on throttle activity and not on elapsed time. Control software drains the store through a small word-addressed register port and rebuilds the waveform of every line from the change events.

The throttle lines are asynchronous to the recorder, so they pass through two flops before the change detector. Recording is gated by an enable bit. Whenever recording is switched on, the first enabled cycle stores the current vector as a starting point. When the store is full, new events are dropped and a sticky flag records the loss. The timestamp counter wraps silently, and a separate counter of its wraps is readable so that long gaps can be measured.

Top module: `thr_hist_recorder`

## Requirements
- R1: After reset the store is empty, the loss flag is clear, recording is disabled, and the status word (address 1) reads 32'h0000_0001.
- R2: While recording is disabled, changes on the throttle lines store nothing.
- R3: A write of 1 to bit 0 of the control word (address 0) while recording is off enables it, and the first enabled cycle stores the current synchronized vector even if it has not changed.
- R4: While enabled, each change of the synchronized vector stores exactly one entry holding the new vector, and steady cycles store nothing.
- R5: The timestamp advances by one every TICK_DIV clocks, so two stored entries differ in timestamp by the tick count between their input changes, modulo 2^TS_W.
- R6: The store holds 2^DEPTH_LOG2 entries. A change that arrives while it is full is dropped, the oldest entries are kept, and the loss flag (status bit 2 and port `overflow`) is set.
- R7: The loss flag stays set until a control write with bit 1 set clears it.
- R8: Reading address 2 returns the oldest entry's timestamp without removing it. Reading address 3 returns its vector and removes the entry. Either read returns zero when the store is empty. Status bit 0 is empty, bit 1 is full, and bits 31:16 hold the entry count.
- R9: Address 4 returns a count that increases by exactly one each time the timestamp wraps from all ones to zero.
- R10: When a capture and a removal fall in the same cycle, both take effect, and the entry count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| throttle_in | input | LINES | Asynchronous throttle lines |
| ctl_addr | input | 3 | Register word address |
| ctl_wr | input | 1 | Register write strobe |
| ctl_rd | input | 1 | Register read strobe |
| ctl_wdata | input | 32 | Write data (control word uses bits 1:0) |
| ctl_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| fifo_empty | output | 1 | Store holds no entry |
| fifo_full | output | 1 | Store holds 2^DEPTH_LOG2 entries |
| overflow | output | 1 | Sticky flag: a change was dropped |

## Verification
A capture and a removing read can land on the same clock edge. The bench provokes this by changing the throttle lines and issuing the vector read exactly three edges later, which matches the two-flop and detector latency. It then expects the removed vector to be the older entry, the entry count to stay at one, and the next read to return the new vector. A second case of the same kind is a drop while the store is full: the bench judges it by the sticky flag and by draining the store to show that only the oldest entries remain.

// File: rtl/thr_hist_pkg.sv
package thr_hist_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_TS    = 3'd2,
    A_STATE = 3'd3,
    A_WRAP  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    SEL_REG   = 2'd0,
    SEL_TS    = 2'd1,
    SEL_STATE = 2'd2,
    SEL_ZERO  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/thr_sync_detect.sv
module thr_sync_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_q,
  output logic         changed
);
  logic [W-1:0] meta_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign changed = (sync_q != prev_q);
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int TS_W     = 32,
  parameter int TICK_DIV = 12
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts,
  output logic [31:0]     wraps
);
  logic tick;

  generate
    if (TICK_DIV > 1) begin : g_presc
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst)                             pre_q <= '0;
        else if (pre_q == PW'(TICK_DIV - 1)) pre_q <= '0;
        else                                 pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PW'(TICK_DIV - 1));
    end else begin : g_direct
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ts    <= '0;
      wraps <= '0;
    end else if (tick) begin
      ts <= ts + 1'b1;
      if (&ts) wraps <= wraps + 1'b1;
    end
  end
endmodule

// File: rtl/event_fifo.sv
module event_fifo #(
  parameter int DW = 64,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          rd_en,
  output logic [DW-1:0] rd_q,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/thr_hist_recorder.sv
module thr_hist_recorder
  import thr_hist_pkg::*;
#(
  parameter int LINES      = 32,
  parameter int TS_W       = 32,
  parameter int TICK_DIV   = 12,
  parameter int DEPTH_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] throttle_in,
  input  logic [2:0]       ctl_addr,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic [31:0]      ctl_wdata,
  output logic [31:0]      ctl_rdata,
  output logic             fifo_empty,
  output logic             fifo_full,
  output logic             overflow
);
  localparam int DW = TS_W + LINES;
  localparam int CW = DEPTH_LOG2 + 1;

  logic [LINES-1:0] thr_now;
  logic             thr_changed;
  logic [TS_W-1:0]  ts_val;
  logic [31:0]      wrap_cnt;

  thr_sync_detect #(.W(LINES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .din     (throttle_in),
    .sync_q  (thr_now),
    .changed (thr_changed)
  );

  ts_counter #(.TS_W(TS_W), .TICK_DIV(TICK_DIV)) u_ts (
    .clk   (clk),
    .rst   (rst),
    .ts    (ts_val),
    .wraps (wrap_cnt)
  );

  logic en_q, base_pend, ovf_q;
  logic wr_ctrl, ovf_clr, rd_ts, rd_state, capture;
  logic unused_wdata;

  assign unused_wdata = ^ctl_wdata[31:2];
  assign wr_ctrl  = ctl_wr && (ctl_addr == A_CTRL);
  assign ovf_clr  = wr_ctrl && ctl_wdata[1];
  assign rd_ts    = ctl_rd && (ctl_addr == A_TS);
  assign rd_state = ctl_rd && (ctl_addr == A_STATE);
  assign capture  = en_q && (base_pend || thr_changed);

  logic [DW-1:0] rd_q;
  logic [CW-1:0] fifo_cnt;
  logic          push_ok, pop_ok;

  event_fifo #(.DW(DW), .AW(DEPTH_LOG2)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (capture),
    .push_data ({ts_val, thr_now}),
    .pop       (rd_state),
    .rd_en     (rd_ts || rd_state),
    .rd_q      (rd_q),
    .count     (fifo_cnt),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      base_pend <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (en_q) base_pend <= 1'b0;
      if (wr_ctrl) begin
        en_q <= ctl_wdata[0];
        if (ctl_wdata[0] && !en_q) base_pend <= 1'b1;
      end
      if (capture && fifo_full) ovf_q <= 1'b1;
      else if (ovf_clr)         ovf_q <= 1'b0;
    end
  end

  assign overflow = ovf_q;

  rd_sel_e     rsel_q;
  logic [31:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= SEL_REG;
      reg_q  <= '0;
    end else if (ctl_rd) begin
      reg_q <= '0;
      case (ctl_addr)
        A_CTRL:  begin rsel_q <= SEL_REG; reg_q <= {31'b0, en_q}; end
        A_STAT:  begin
          rsel_q <= SEL_REG;
          reg_q  <= {16'(fifo_cnt), 13'b0, ovf_q, fifo_full, fifo_empty};
        end
        A_WRAP:  begin rsel_q <= SEL_REG; reg_q <= wrap_cnt; end
        A_TS:    rsel_q <= fifo_empty ? SEL_ZERO : SEL_TS;
        A_STATE: rsel_q <= fifo_empty ? SEL_ZERO : SEL_STATE;
        default: rsel_q <= SEL_REG;
      endcase
    end
  end

  always_comb begin
    case (rsel_q)
      SEL_TS:    ctl_rdata = 32'(rd_q[DW-1:LINES]);
      SEL_STATE: ctl_rdata = 32'(rd_q[LINES-1:0]);
      SEL_ZERO:  ctl_rdata = '0;
      default:   ctl_rdata = reg_q;
    endcase
  end
endmodule

// File: rtl/thr_hist_chk.sv
module thr_hist_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          capture,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          rd_ts,
  input logic          ovf_clr,
  input logic [CW-1:0] fifo_cnt,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic          overflow,
  input logic [31:0]   wrap_cnt
);
  p_full_holds_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_full && !pop_ok |=> fifo_full);

  p_drop_flags_r6: assert property (@(posedge clk) disable iff (rst)
    capture && fifo_full |=> overflow);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    overflow && !ovf_clr |=> overflow);

  p_ts_read_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    rd_ts && !push_ok |=> fifo_cnt == $past(fifo_cnt));

  p_empty_stays_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_empty && !push_ok |=> fifo_empty);

  p_push_grows_r4: assert property (@(posedge clk) disable iff (rst)
    push_ok && !pop_ok |=> fifo_cnt == CW'($past(fifo_cnt) + 1'b1));

  p_wrap_step_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wrap_cnt == $past(wrap_cnt)) || (wrap_cnt == $past(wrap_cnt) + 32'd1));

  p_pair_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    push_ok && pop_ok |=> fifo_cnt == $past(fifo_cnt));
endmodule

bind thr_hist_recorder thr_hist_chk #(.CW(DEPTH_LOG2 + 1)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .capture    (capture),
  .push_ok    (push_ok),
  .pop_ok     (pop_ok),
  .rd_ts      (rd_ts),
  .ovf_clr    (ovf_clr),
  .fifo_cnt   (fifo_cnt),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .overflow   (overflow),
  .wrap_cnt   (wrap_cnt)
);

// File: tb/thr_hist_recorder_bench.sv
module thr_hist_recorder_bench;
  localparam int LINES = 32;
  localparam int TS_W  = 8;
  localparam int AW    = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LINES-1:0] throttle_in = '0;
  logic [2:0]       ctl_addr = '0;
  logic             ctl_wr = 1'b0;
  logic             ctl_rd = 1'b0;
  logic [31:0]      ctl_wdata = '0;
  logic [31:0]      ctl_rdata;
  logic             fifo_empty, fifo_full, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  thr_hist_recorder #(.LINES(LINES), .TS_W(TS_W), .TICK_DIV(1), .DEPTH_LOG2(AW))
    u_thr_hist_recorder (
      .clk(clk), .rst(rst), .throttle_in(throttle_in),
      .ctl_addr(ctl_addr), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
      .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overflow(overflow));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    ctl_addr = a; ctl_wdata = d; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    ctl_addr = a; ctl_rd = 1'b1;
    @(negedge clk);
    ctl_rd = 1'b0;
    d = ctl_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(3'd1, d);
    check(d == 32'h0000_0001, "R1 status", d, 32'h0000_0001);
    check(overflow == 1'b0, "R1 overflow port", 32'(overflow), 32'h0);
    rd_reg(3'd0, d);
    check(d == 32'h0, "R1 control", d, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    throttle_in = 32'h0000_00F0; idle(4);
    throttle_in = 32'h0000_0A0A; idle(5);
    rd_reg(3'd1, d);
    check(d == 32'h0000_0001, "R2 nothing stored while off", d, 32'h0000_0001);
  endtask

  task automatic t_baseline();
    logic [31:0] d;
    wr_reg(3'd0, 32'h1); idle(3);
    rd_reg(3'd1, d);
    check(d == 32'h0001_0000, "R3 baseline count", d, 32'h0001_0000);
    rd_reg(3'd2, d);
    rd_reg(3'd3, d);
    check(d == 32'h0000_0A0A, "R3 baseline state", d, 32'h0000_0A0A);
  endtask

  task automatic t_changes();
    logic [31:0] d, t1, t2;
    throttle_in = 32'hB000_0001; idle(7);
    throttle_in = 32'hC000_0002; idle(6);
    rd_reg(3'd1, d);
    check(d == 32'h0002_0000, "R4 one entry per change", d, 32'h0002_0000);
    rd_reg(3'd2, t1);
    rd_reg(3'd3, d);
    check(d == 32'hB000_0001, "R4 first state", d, 32'hB000_0001);
    rd_reg(3'd2, t2);
    rd_reg(3'd3, d);
    check(d == 32'hC000_0002, "R4 second state", d, 32'hC000_0002);
    check(((t2 - t1) & 32'hFF) == 32'd7, "R5 timestamp delta", (t2 - t1) & 32'hFF, 32'd7);
  endtask

  task automatic t_readproto();
    logic [31:0] d, a, b;
    throttle_in = 32'h0000_0077; idle(5);
    rd_reg(3'd2, a);
    rd_reg(3'd2, b);
    check(a == b, "R8 timestamp read repeats", b, a);
    rd_reg(3'd1, d);
    check(d == 32'h0001_0000, "R8 timestamp read keeps entry", d, 32'h0001_0000);
    rd_reg(3'd3, d);
    check(d == 32'h0000_0077, "R8 state read", d, 32'h0000_0077);
    rd_reg(3'd3, d);
    check(d == 32'h0, "R8 empty read zero", d, 32'h0);
    rd_reg(3'd1, d);
    check(d == 32'h0000_0001, "R8 empty after pop", d, 32'h0000_0001);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    for (int i = 0; i < 10; i++) begin
      throttle_in = 32'h100 + 32'(i); idle(3);
    end
    idle(5);
    rd_reg(3'd1, d);
    check(d == 32'h0008_0006, "R6 full with loss", d, 32'h0008_0006);
    check(overflow == 1'b1, "R6 overflow port", 32'(overflow), 32'h1);
    for (int i = 0; i < 8; i++) begin
      rd_reg(3'd2, d);
      rd_reg(3'd3, d);
      check(d == 32'h100 + 32'(i), "R6 oldest kept", d, 32'h100 + 32'(i));
    end
    rd_reg(3'd1, d);
    check(d == 32'h0000_0005, "R7 flag sticky after drain", d, 32'h0000_0005);
    wr_reg(3'd0, 32'h3);
    check(overflow == 1'b0, "R7 flag cleared", 32'(overflow), 32'h0);
    rd_reg(3'd1, d);
    check(d == 32'h0000_0001, "R7 status after clear", d, 32'h0000_0001);
  endtask

  task automatic t_wrap();
    logic [31:0] w0, w1;
    rd_reg(3'd4, w0);
    idle(255);
    rd_reg(3'd4, w1);
    check(w1 == w0 + 32'd1, "R9 one wrap per 256 ticks", w1, w0 + 32'd1);
  endtask

  task automatic t_simul();
    logic [31:0] d;
    throttle_in = 32'h0000_0055; idle(5);
    throttle_in = 32'h0000_00EE;
    idle(2);
    rd_reg(3'd3, d);
    check(d == 32'h0000_0055, "R10 popped older entry", d, 32'h0000_0055);
    idle(1);
    rd_reg(3'd1, d);
    check(d == 32'h0001_0000, "R10 count unchanged", d, 32'h0001_0000);
    rd_reg(3'd3, d);
    check(d == 32'h0000_00EE, "R10 new entry kept", d, 32'h0000_00EE);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_baseline();
    t_changes();
    t_readproto();
    t_overflow();
    t_wrap();
    t_simul();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule